// File: doc/BRIEF.md
# Host/Processor Interrupt Handshake Register

A small flag register sitting between a host system and an embedded processor. Both sides raise interrupts through it. The host raises a request to the processor by writing a command bit, and the processor acknowledges by writing a 1 to the same flag. The processor raises a request to the host by writing a 1 to its outbound flag, and the host acknowledges through its own acknowledge bit. A mask gates the host request on its way to the processor. A host-side wait control suppresses the interrupt line to the host.

A power-down completion pulse sets a done flag, which interrupts the processor regardless of the mask. Clearing that flag takes two steps. Writing a 1 clears the flag and holds it cleared, and while the hold is in place the flag reads 0 and ignores completion pulses. A later write of 0 releases the hold. All state resets to 0 on an active-low asynchronous reset.

Top module: `irq_hsk_reg`

## Requirements
- R1: While reset is asserted and on the first cycle after it, cpu_rdata_o is 0 and both interrupt outputs are 0.
- R2: A host write with host_wdata_i bit 0 (command) = 1 sets the host-to-processor flag (cpu_rdata_o bit 1) on the next cycle. A processor write with cpu_wdata_i bit 1 = 1 clears it. A host write with bit 0 = 0 leaves it unchanged.
- R3: cpu_irq_o reflects the host-to-processor flag only while the mask (cpu_rdata_o bit 2) is 1. Every processor write loads the mask from cpu_wdata_i bit 2.
- R4: A processor write with cpu_wdata_i bit 0 = 1 sets the processor-to-host flag (cpu_rdata_o bit 0). A processor write with bit 0 = 0 leaves it unchanged.
- R5: A host write with host_wdata_i bit 1 (acknowledge) = 1 clears the processor-to-host flag.
- R6: host_irq_o equals the processor-to-host flag while host_wait_i is 0, and is 0 while host_wait_i is 1.
- R7: A done_set_i pulse sets the done flag (cpu_rdata_o bit 3) when no hold is in place, and a set done flag drives cpu_irq_o high whatever the mask.
- R8: A processor write with cpu_wdata_i bit 3 = 1 clears the done flag and holds it. While held, the flag reads 0 and ignores done_set_i, including a pulse in the same cycle as that write.
- R9: A processor write with cpu_wdata_i bit 3 = 0 releases the hold without clearing a set done flag. A done_set_i pulse in the releasing cycle or later sets the flag.
- R10: When a set and a clear of the same interrupt flag arrive in one cycle, the set wins for both the host-to-processor and the processor-to-host flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cpu_wr_i | input | 1 | Processor write strobe |
| cpu_wdata_i | input | DATA_W | Processor write data |
| host_wr_i | input | 1 | Host write strobe |
| host_wdata_i | input | DATA_W | Host write data |
| host_wait_i | input | 1 | Host wait control; 1 suppresses host_irq_o |
| done_set_i | input | 1 | Power-down completion pulse |
| cpu_rdata_o | output | DATA_W | Flag read-back {0, done, mask, h2c, c2h} |
| cpu_irq_o | output | 1 | Interrupt to processor |
| host_irq_o | output | 1 | Interrupt to host |

## Verification
The checker watches several behaviours on every cycle. It checks that each set strobe takes effect on the next cycle, that an acknowledge without a competing set clears the outbound flag, and that a zero write leaves the outbound flag as it was. It also checks that the wait control always silences the host line, that a clear mask with a clear done flag keeps the processor line low, and that a write of 1 to the done bit reads back 0 on the next cycle. Other behaviours show up only in the bench's ordered scenarios. These are the hold that keeps swallowing completion pulses across idle cycles, the release that lets a later pulse through, the same-cycle races between hold and pulse, and the set-wins races on both interrupt flags.

// File: rtl/hsk_pkg.sv
package hsk_pkg;
  // processor-side bit positions (write and read-back)
  localparam int unsigned CB_C2H  = 0;
  localparam int unsigned CB_H2C  = 1;
  localparam int unsigned CB_MASK = 2;
  localparam int unsigned CB_DONE = 3;
  // host-side bit positions
  localparam int unsigned HB_CMD  = 0;
  localparam int unsigned HB_ACK  = 1;
  localparam int unsigned USED_W  = 4;
endpackage

// File: rtl/hsk_flag_cell.sv
module hsk_flag_cell #(
  parameter bit SET_WINS = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  logic q_d, q_q;

  generate
    if (SET_WINS) begin : g_set_prio
      always_comb begin
        q_d = q_q;
        if (clr_i) q_d = 1'b0;
        if (set_i) q_d = 1'b1;
      end
    end else begin : g_clr_prio
      always_comb begin
        q_d = q_q;
        if (set_i) q_d = 1'b1;
        if (clr_i) q_d = 1'b0;
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= 1'b0;
    else         q_q <= q_d;
  end

  assign q_o = q_q;
endmodule

// File: rtl/hsk_done_cell.sv
module hsk_done_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_i,
  input  logic wbit_i,
  input  logic set_i,
  output logic done_o
);
  logic hold_d, hold_q;
  logic done_d, done_q;

  // hold follows the last written value; it dominates the set pulse
  always_comb begin
    hold_d = wr_i ? wbit_i : hold_q;
    done_d = done_q;
    if (set_i)  done_d = 1'b1;
    if (hold_d) done_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      hold_q <= hold_d;
      done_q <= done_d;
    end
  end

  assign done_o = done_q;
endmodule

// File: rtl/hsk_irq_combine.sv
module hsk_irq_combine (
  input  logic h2c_i,
  input  logic mask_i,
  input  logic done_i,
  input  logic c2h_i,
  input  logic wait_i,
  output logic cpu_irq_o,
  output logic host_irq_o
);
  assign cpu_irq_o  = (h2c_i & mask_i) | done_i;
  assign host_irq_o = c2h_i & ~wait_i;
endmodule

// File: rtl/irq_hsk_reg.sv
module irq_hsk_reg
  import hsk_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_wr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  input  logic              host_wr_i,
  input  logic [DATA_W-1:0] host_wdata_i,
  input  logic              host_wait_i,
  input  logic              done_set_i,
  output logic [DATA_W-1:0] cpu_rdata_o,
  output logic              cpu_irq_o,
  output logic              host_irq_o
);
  localparam int unsigned PAD_W = DATA_W - USED_W;

  logic c2h_q, h2c_q, mask_q, done_q;
  logic unused_bits;

  assign unused_bits = ^{cpu_wdata_i, host_wdata_i};

  // processor-to-host: processor sets, host acknowledges
  hsk_flag_cell #(.SET_WINS(1'b1)) u_c2h (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (cpu_wr_i & cpu_wdata_i[CB_C2H]),
    .clr_i (host_wr_i & host_wdata_i[HB_ACK]),
    .q_o   (c2h_q)
  );

  // host-to-processor: host commands, processor clears by writing 1
  hsk_flag_cell #(.SET_WINS(1'b1)) u_h2c (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (host_wr_i & host_wdata_i[HB_CMD]),
    .clr_i (cpu_wr_i & cpu_wdata_i[CB_H2C]),
    .q_o   (h2c_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       mask_q <= 1'b0;
    else if (cpu_wr_i) mask_q <= cpu_wdata_i[CB_MASK];
  end

  hsk_done_cell u_done (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .wr_i  (cpu_wr_i),
    .wbit_i(cpu_wdata_i[CB_DONE]),
    .set_i (done_set_i),
    .done_o(done_q)
  );

  hsk_irq_combine u_irq (
    .h2c_i     (h2c_q),
    .mask_i    (mask_q),
    .done_i    (done_q),
    .c2h_i     (c2h_q),
    .wait_i    (host_wait_i),
    .cpu_irq_o (cpu_irq_o),
    .host_irq_o(host_irq_o)
  );

  generate
    if (PAD_W > 0) begin : g_pad
      assign cpu_rdata_o = {{PAD_W{1'b0}}, done_q, mask_q, h2c_q, c2h_q};
    end else begin : g_nopad
      assign cpu_rdata_o = {done_q, mask_q, h2c_q, c2h_q};
    end
  endgenerate
endmodule

// File: rtl/irq_hsk_reg_chk.sv
module irq_hsk_reg_chk
  import hsk_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cpu_wr_i,
  input logic [DATA_W-1:0] cpu_wdata_i,
  input logic              host_wr_i,
  input logic [DATA_W-1:0] host_wdata_i,
  input logic              host_wait_i,
  input logic              done_set_i,
  input logic [DATA_W-1:0] cpu_rdata_o,
  input logic              cpu_irq_o,
  input logic              host_irq_o
);
  logic unused_chk;
  assign unused_chk = done_set_i;

  // R2 R10
  h2c_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_wr_i && host_wdata_i[HB_CMD]) |=> cpu_rdata_o[CB_H2C]);

  // R4 R10
  c2h_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_wr_i && cpu_wdata_i[CB_C2H]) |=> cpu_rdata_o[CB_C2H]);

  // R4
  c2h_zero_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_wr_i && !cpu_wdata_i[CB_C2H] && !(host_wr_i && host_wdata_i[HB_ACK]))
    |=> $stable(cpu_rdata_o[CB_C2H]));

  // R5
  c2h_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_wr_i && host_wdata_i[HB_ACK] && !(cpu_wr_i && cpu_wdata_i[CB_C2H]))
    |=> !cpu_rdata_o[CB_C2H]);

  // R6
  host_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_wait_i |-> !host_irq_o);

  // R3
  cpu_masked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cpu_rdata_o[CB_MASK] && !cpu_rdata_o[CB_DONE]) |-> !cpu_irq_o);

  // R7
  done_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_rdata_o[CB_DONE] |-> cpu_irq_o);

  // R8
  done_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_wr_i && cpu_wdata_i[CB_DONE]) |=> !cpu_rdata_o[CB_DONE]);
endmodule

bind irq_hsk_reg irq_hsk_reg_chk #(.DATA_W(DATA_W)) chk_i (.*);

// File: tb/irq_hsk_reg_tb_top.sv
`timescale 1ns/1ps
module irq_hsk_reg_tb_top;
  localparam int DATA_W = 8;

  typedef struct {
    logic [DATA_W-1:0] rdata;
    logic              cirq;
    logic              hirq;
    string             tag;
  } exp_t;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              cpu_wr_i = 1'b0;
  logic [DATA_W-1:0] cpu_wdata_i = '0;
  logic              host_wr_i = 1'b0;
  logic [DATA_W-1:0] host_wdata_i = '0;
  logic              host_wait_i = 1'b0;
  logic              done_set_i = 1'b0;
  logic [DATA_W-1:0] cpu_rdata_o;
  logic              cpu_irq_o;
  logic              host_irq_o;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;
  exp_t q[$];

  logic m_c2h = 0, m_h2c = 0, m_mask = 0, m_done = 0, m_hold = 0;

  always #2 clk_i = ~clk_i;

  irq_hsk_reg #(.DATA_W(DATA_W)) dut_i (.*);

  task automatic compare(exp_t e);
    n_chk++;
    if (cpu_rdata_o !== e.rdata || cpu_irq_o !== e.cirq || host_irq_o !== e.hirq) begin
      n_fail++;
      $display("FAIL %s: rdata=%h cirq=%b hirq=%b expected rdata=%h cirq=%b hirq=%b",
               e.tag, cpu_rdata_o, cpu_irq_o, host_irq_o, e.rdata, e.cirq, e.hirq);
    end
  endtask

  // driver: drive one cycle of stimulus and push the post-edge expectation
  task automatic step(input logic cw, input logic [3:0] cd, input logic hw,
                      input logic [1:0] hd, input logic wt, input logic ds,
                      input string tag);
    exp_t e;
    logic c2h_n, h2c_n, mask_n, hold_n, done_n;
    @(negedge clk_i);
    cpu_wr_i = cw; cpu_wdata_i = {4'b0, cd};
    host_wr_i = hw; host_wdata_i = {6'b0, hd};
    host_wait_i = wt; done_set_i = ds;
    c2h_n  = (cw && cd[0]) ? 1'b1 : (hw && hd[1]) ? 1'b0 : m_c2h;
    h2c_n  = (hw && hd[0]) ? 1'b1 : (cw && cd[1]) ? 1'b0 : m_h2c;
    mask_n = cw ? cd[2] : m_mask;
    hold_n = cw ? cd[3] : m_hold;
    done_n = hold_n ? 1'b0 : ds ? 1'b1 : m_done;
    m_c2h = c2h_n; m_h2c = h2c_n; m_mask = mask_n; m_hold = hold_n; m_done = done_n;
    e.rdata = {4'b0, m_done, m_mask, m_h2c, m_c2h};
    e.cirq  = (m_h2c & m_mask) | m_done;
    e.hirq  = m_c2h & ~wt;
    e.tag   = tag;
    q.push_back(e);
  endtask

  // monitor
  always @(posedge clk_i) begin
    #1;
    if (q.size() > 0) compare(q.pop_front());
  end

  initial begin : watchdog
    repeat (5000) @(posedge clk_i);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=expired expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    exp_t r;
    repeat (2) @(negedge clk_i);
    r.rdata = '0; r.cirq = 0; r.hirq = 0; r.tag = "R1 in reset";
    compare(r);
    rst_ni = 1'b1;
    step(0, 4'h0, 0, 2'd0, 0, 0, "R1 first cycle");
    step(0, 4'h0, 1, 2'd1, 0, 0, "R2 set, R3 masked");
    step(1, 4'h4, 0, 2'd0, 0, 0, "R3 unmask");
    step(0, 4'h0, 1, 2'd0, 0, 0, "R2 zero cmd no effect");
    step(1, 4'h6, 0, 2'd0, 0, 0, "R2 processor clear");
    step(1, 4'h5, 0, 2'd0, 0, 0, "R4 set, R6 line");
    step(1, 4'h4, 0, 2'd0, 0, 0, "R4 zero write no effect");
    step(0, 4'h0, 0, 2'd0, 1, 0, "R6 wait blocks");
    step(0, 4'h0, 0, 2'd0, 0, 0, "R6 wait released");
    step(0, 4'h0, 1, 2'd2, 0, 0, "R5 ack clears");
    step(1, 4'h7, 1, 2'd3, 0, 0, "R10 set wins both");
    step(1, 4'h2, 1, 2'd2, 0, 0, "R5 ack, R2 clear");
    step(0, 4'h0, 0, 2'd0, 0, 1, "R7 done sets");
    step(1, 4'h0, 0, 2'd0, 0, 0, "R9 zero write keeps done");
    step(1, 4'h8, 0, 2'd0, 0, 0, "R8 hold clears");
    step(0, 4'h0, 0, 2'd0, 0, 1, "R8 pulse ignored");
    step(0, 4'h0, 0, 2'd0, 0, 0, "R8 still held");
    step(1, 4'h0, 0, 2'd0, 0, 0, "R9 release");
    step(0, 4'h0, 0, 2'd0, 0, 1, "R9 set after release");
    step(1, 4'h8, 0, 2'd0, 0, 1, "R8 hold beats same-cycle pulse");
    step(1, 4'h0, 0, 2'd0, 0, 1, "R9 release with same-cycle pulse");
    step(0, 4'h0, 1, 2'd1, 0, 0, "R3 done drives irq with mask clear");
    step(0, 4'h0, 0, 2'd0, 0, 0, "R7 idle hold of state");
    @(negedge clk_i);
    @(negedge clk_i);
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule